// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block models the device side of the period in which sector erase requests are gathered before an internal erase starts. Each sector erase request arrives as a command transfer that carries a sector index. The first accepted request opens an acceptance window and marks its sector in a selection bitmap. Every later request that is accepted inside the window marks another sector and restarts the full timeout. When the window runs out with no new request, the internal erase begins. The status bit `dq3` then goes from 0 to 1, and every command except erase suspend is locked out until an external erase-done strobe returns the block to idle.

A whole-chip erase request does not use the window. Taken in idle, it starts the erase on the next cycle with every sector selected. The block does not decode command unlock sequences and does not run the erase algorithm. Its outputs tell the erase engine when to start and which sectors to work on. The suspend request is forwarded to the erase engine only while an erase is running.

The sector request port follows valid/ready rules. A transfer happens on a clock edge where `sec_valid` and `sec_ready` are both high. While `sec_ready` is low, a presented request has no effect and is not held. A sender that needs the request taken must check `dq3` and `window_open` and issue the request again.

Top module: `sera_window`

## Requirements
- R1: After reset, or on a reset in the middle of a window, `dq3`=0, `window_open`=0, `erase_start`=0, `sector_map`=0 and `sec_ready`=1.
- R2: A sector request accepted in idle opens the window on the next cycle. It sets bit `sec_idx` of `sector_map` (bit n is sector n), and `dq3` stays 0.
- R3: The erase begins (`dq3`=1, `window_open`=0) exactly TIMEOUT clock edges after the edge that accepted the most recent sector request.
- R4: A sector request accepted while the window is open adds its bit to `sector_map` and restarts the full TIMEOUT count. Repeating an index that is already selected leaves the map unchanged.
- R5: In the last window cycle, the one whose edge starts the erase, `sec_ready` is 0. A request presented then sets no bit and does not restart the window.
- R6: While `dq3`=1, `sec_ready` is 0, and sector or chip erase requests change neither `sector_map` nor `dq3`.
- R7: `erase_start` is high for exactly one cycle, the first cycle with `dq3`=1.
- R8: A chip erase request in idle makes `dq3`=1 and `sector_map` all ones on the next cycle, with no window. A chip erase request while the window is open is ignored.
- R9: `suspend_out` equals `suspend_req` while `dq3`=1 and is 0 otherwise.
- R10: `erase_done` while `dq3`=1 returns the block to idle on the next cycle with `dq3`=0 and `sector_map`=0. In idle or in the window, `erase_done` has no effect.
- R11: TIMEOUT equals CLK_MHZ × WINDOW_US cycles. The defaults (100 MHz, 50 µs) give 5000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_valid | input | 1 | Sector erase request presented |
| sec_ready | output | 1 | Sector request can be taken this cycle |
| sec_idx | input | $clog2(NUM_SECTORS) | Sector index of the request |
| chip_erase | input | 1 | Whole-chip erase request strobe |
| erase_done | input | 1 | Erase engine reports completion |
| suspend_req | input | 1 | Erase suspend request |
| dq3 | output | 1 | Timer status: 1 once the internal erase has begun |
| window_open | output | 1 | Acceptance window running |
| erase_start | output | 1 | One-cycle pulse when the erase begins |
| sector_map | output | NUM_SECTORS | Selected sectors, bit n is sector n |
| suspend_out | output | 1 | Suspend forwarded to the erase engine |

## Verification
The window is tried with requests spaced well inside the timeout, one cycle short of it, and exactly at its final cycle. These cases separate a restart of the count from plain accumulation, and they separate an off-by-one expiry from the correct one. Requests presented during the erase, a chip erase during the window, and a stray erase-done outside an erase show whether the lockout and the ignore rules hold. The chip erase path from idle is compared with the sector path by the map it leaves behind and by the fact that it skips the window.

// File: rtl/sera_pkg.sv
package sera_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2
  } sera_state_e;
endpackage

// File: rtl/sera_timer.sv
// Restartable window counter; expire flags the final window cycle.
module sera_timer #(
  parameter int unsigned TIMEOUT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart)       cnt_q <= '0;
    else if (run && !expire) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/sera_map.sv
// Sector selection bitmap, one flop per sector.
module sera_map #(
  parameter int unsigned NUM_SECTORS = 16,
  parameter int unsigned IW = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic [IW-1:0]          set_idx,
  input  logic                   fill_all,
  input  logic                   clear,
  output logic [NUM_SECTORS-1:0] map
);
  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || clear)                           map[i] <= 1'b0;
      else if (fill_all)                             map[i] <= 1'b1;
      else if (set_en && (set_idx == IW'(i)))        map[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sera_ctrl.sv
// Idle / window / erase sequencing and command gating.
module sera_ctrl
  import sera_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_valid,
  input  logic        chip_erase,
  input  logic        erase_done,
  input  logic        expire,
  output sera_state_e state,
  output logic        sec_ready,
  output logic        sec_fire,
  output logic        map_fill,
  output logic        map_clear,
  output logic        erase_start
);
  sera_state_e state_q, state_d;

  assign state     = state_q;
  assign sec_ready = ((state_q == ST_IDLE) && !chip_erase) ||
                     ((state_q == ST_WINDOW) && !expire);
  assign sec_fire  = sec_valid && sec_ready;
  assign map_fill  = (state_q == ST_IDLE) && chip_erase;
  assign map_clear = (state_q == ST_ERASE) && erase_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (chip_erase)     state_d = ST_ERASE;
        else if (sec_valid) state_d = ST_WINDOW;
      end
      ST_WINDOW: if (expire)     state_d = ST_ERASE;
      ST_ERASE:  if (erase_done) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      erase_start <= 1'b0;
    end else begin
      state_q     <= state_d;
      erase_start <= (state_q != ST_ERASE) && (state_d == ST_ERASE);
    end
  end
endmodule

// File: rtl/sera_window.sv
module sera_window
  import sera_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned WINDOW_US   = 50,
  parameter int unsigned NUM_SECTORS = 16,
  localparam int unsigned IW         = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sec_valid,
  output logic                   sec_ready,
  input  logic [IW-1:0]          sec_idx,
  input  logic                   chip_erase,
  input  logic                   erase_done,
  input  logic                   suspend_req,
  output logic                   dq3,
  output logic                   window_open,
  output logic                   erase_start,
  output logic [NUM_SECTORS-1:0] sector_map,
  output logic                   suspend_out
);
  localparam int unsigned TIMEOUT = CLK_MHZ * WINDOW_US;

  sera_state_e state;
  logic        expire, sec_fire, map_fill, map_clear;

  sera_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_valid   (sec_valid),
    .chip_erase  (chip_erase),
    .erase_done  (erase_done),
    .expire      (expire),
    .state       (state),
    .sec_ready   (sec_ready),
    .sec_fire    (sec_fire),
    .map_fill    (map_fill),
    .map_clear   (map_clear),
    .erase_start (erase_start)
  );

  sera_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (sec_fire),
    .run     (state == ST_WINDOW),
    .expire  (expire)
  );

  sera_map #(.NUM_SECTORS(NUM_SECTORS), .IW(IW)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (sec_fire),
    .set_idx  (sec_idx),
    .fill_all (map_fill),
    .clear    (map_clear),
    .map      (sector_map)
  );

  assign dq3         = (state == ST_ERASE);
  assign window_open = (state == ST_WINDOW);
  assign suspend_out = suspend_req && (state == ST_ERASE);
endmodule

// File: rtl/sera_window_chk.sv
module sera_window_chk #(
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned WINDOW_US   = 50,
  parameter int unsigned NUM_SECTORS = 16,
  parameter int unsigned IW          = $clog2(NUM_SECTORS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sec_valid,
  input logic                   sec_ready,
  input logic [IW-1:0]          sec_idx,
  input logic                   chip_erase,
  input logic                   erase_done,
  input logic                   suspend_req,
  input logic                   dq3,
  input logic                   window_open,
  input logic                   erase_start,
  input logic [NUM_SECTORS-1:0] sector_map,
  input logic                   suspend_out
);
  localparam int unsigned TIMEOUT = CLK_MHZ * WINDOW_US;

  logic [31:0] wcnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                      wcnt <= '0;
    else if (sec_valid && sec_ready) wcnt <= '0;
    else if (window_open)            wcnt <= wcnt + 32'd1;
  end

  AST_OPEN_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!dq3 && !window_open && sec_valid && sec_ready) |=> (window_open && !dq3 && sector_map[$past(sec_idx)])); // R2
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    window_open |-> (wcnt < TIMEOUT)); // R3
  AST_EXPIRE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && wcnt == TIMEOUT - 1) |=> (dq3 && !window_open)); // R3
  AST_LAST_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && wcnt == TIMEOUT - 1) |-> !sec_ready); // R5
  AST_LOCK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    dq3 |-> !sec_ready); // R6
  AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dq3 && !erase_done) |=> (dq3 && $stable(sector_map))); // R6
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start); // R7
  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq3) |-> erase_start); // R7
  AST_CHIP_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!dq3 && !window_open && chip_erase) |=> (dq3 && (&sector_map))); // R8
  AST_SUSP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_out |-> (dq3 && suspend_req)); // R9
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (dq3 && erase_done) |=> (!dq3 && sector_map == '0)); // R10
endmodule

bind sera_window sera_window_chk #(
  .CLK_MHZ(CLK_MHZ), .WINDOW_US(WINDOW_US), .NUM_SECTORS(NUM_SECTORS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_valid(sec_valid), .sec_ready(sec_ready),
  .sec_idx(sec_idx), .chip_erase(chip_erase), .erase_done(erase_done),
  .suspend_req(suspend_req), .dq3(dq3), .window_open(window_open),
  .erase_start(erase_start), .sector_map(sector_map), .suspend_out(suspend_out)
);

// File: tb/sim_sera_window.sv
`timescale 1ns/1ps
module sim_sera_window;
  localparam int NS = 16;
  localparam int OP_NOP = 0, OP_SEC = 1, OP_CHIP = 2, OP_DONE = 3;
  // {op[2], idx[4], extra_edges[8], exp_map[16], exp_dq3[1]}; timeout = 1 MHz x 50 us = 50
  localparam logic [30:0] VEC [0:7] = '{
    {2'd1, 4'd3, 8'd10, 16'h0008, 1'b0},
    {2'd1, 4'd7, 8'd40, 16'h0088, 1'b0},
    {2'd1, 4'd0, 8'd49, 16'h0089, 1'b0},
    {2'd0, 4'd0, 8'd0,  16'h0089, 1'b1},
    {2'd3, 4'd0, 8'd0,  16'h0000, 1'b0},
    {2'd2, 4'd0, 8'd0,  16'hFFFF, 1'b1},
    {2'd1, 4'd5, 8'd0,  16'hFFFF, 1'b1},
    {2'd3, 4'd0, 8'd0,  16'h0000, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sec_valid = 1'b0, chip_erase = 1'b0, erase_done = 1'b0, suspend_req = 1'b0;
  logic [3:0] sec_idx = '0;
  logic sec_ready, dq3, window_open, erase_start, suspend_out;
  logic [NS-1:0] sector_map;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  sera_window #(.CLK_MHZ(1), .WINDOW_US(50), .NUM_SECTORS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_valid(sec_valid), .sec_ready(sec_ready),
    .sec_idx(sec_idx), .chip_erase(chip_erase), .erase_done(erase_done),
    .suspend_req(suspend_req), .dq3(dq3), .window_open(window_open),
    .erase_start(erase_start), .sector_map(sector_map), .suspend_out(suspend_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the capturing edge.
  task automatic do_op(input int op, input logic [3:0] idx);
    sec_valid  = (op == OP_SEC);
    sec_idx    = idx;
    chip_erase = (op == OP_CHIP);
    erase_done = (op == OP_DONE);
    @(posedge clk);
    @(negedge clk);
    sec_valid = 1'b0; chip_erase = 1'b0; erase_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 dq3", dq3, 0);
    chk("R1 window", window_open, 0);
    chk("R1 map", sector_map, 0);
    chk("R1 ready", sec_ready, 1);
    chk("R1 start", erase_start, 0);

    // Vector walk: R2 R3 R4 R6 R8 R10 R11
    for (int i = 0; i < 8; i++) begin
      logic [30:0] v;
      v = VEC[i];
      do_op(int'(v[30:29]), v[28:25]);
      repeat (int'(v[24:17])) @(negedge clk);
      chk($sformatf("R2/R3/R4/R11 row%0d map", i), sector_map, v[16:1]);
      chk($sformatf("R3/R6/R8/R10 row%0d dq3", i), dq3, v[0]);
    end

    // R5 and R7: request in the final window cycle
    do_op(OP_SEC, 4'd2);
    repeat (48) @(negedge clk);
    chk("R4 ready before last", sec_ready, 1);
    @(negedge clk);
    chk("R5 ready in last cycle", sec_ready, 0);
    do_op(OP_SEC, 4'd9);
    chk("R5 map unchanged", sector_map, 16'h0004);
    chk("R3 erase begun", dq3, 1);
    chk("R7 start high", erase_start, 1);
    // R9 suspend forwarding while erasing
    suspend_req = 1'b1; #1;
    chk("R9 suspend while erase", suspend_out, 1);
    suspend_req = 1'b0;
    @(negedge clk);
    chk("R7 start one cycle", erase_start, 0);
    do_op(OP_CHIP, 4'd0);
    chk("R6 chip locked out", sector_map, 16'h0004);
    do_op(OP_DONE, 4'd0);
    chk("R10 idle dq3", dq3, 0);
    chk("R10 map cleared", sector_map, 0);
    suspend_req = 1'b1; #1;
    chk("R9 suspend idle", suspend_out, 0);
    suspend_req = 1'b0;
    do_op(OP_DONE, 4'd0);
    chk("R10 done in idle", {window_open, dq3, sec_ready}, 3'b001);

    // R8 chip erase in window ignored, R10 done in window ignored, R4 repeat index
    do_op(OP_SEC, 4'd1);
    do_op(OP_CHIP, 4'd0);
    chk("R8 chip in window map", sector_map, 16'h0002);
    chk("R8 chip in window state", {window_open, dq3}, 2'b10);
    do_op(OP_DONE, 4'd0);
    chk("R10 done in window", sector_map, 16'h0002);
    do_op(OP_SEC, 4'd6);
    do_op(OP_SEC, 4'd6);
    chk("R4 repeat index", sector_map, 16'h0042);

    // R1 reset in mid window
    do_reset();
    chk("R1 mid reset map", sector_map, 0);
    chk("R1 mid reset window", window_open, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule